// File: doc/BRIEF.md
# Multiplexed Three-Digit BCD Counter

This block counts events in decimal across three cascaded decades, units, tens and hundreds, so the count runs from 000 to 999 and then wraps. An event is a high-to-low transition of the count clock while the count is enabled. Each decade has a 4-bit hold stage. While the hold stage is open it passes the live digit. While it is closed it keeps the digit it last saw, and the count keeps running underneath.

The stored digits reach the outside over a single shared 4-bit BCD bus, one digit at a time. A one-hot select bus names the digit on the bus. A scan tick from a free-running divider moves the presentation on to the next digit, independently of counting. A carry flag marks the wrap from 999 to 000 so that further counter stages can be chained after this one.

Everything runs on one fast system clock. The count clock and the other control inputs are sampled on that clock.

Top module: `bcd_scan_counter`

## Requirements
- R1: After rst_ni is asserted low, the count is 000, the units digit is selected (dig_sel_o = 3'b001), bcd_o is 0 and carry_o is 0.
- R2: The count rises by one on the clk_i edge that first samples cnt_clk_i low after sampling it high. A rising or steady cnt_clk_i leaves the count unchanged.
- R3: The count is decimal, modulo 1000. A units roll from 9 to 0 carries into tens, and a tens roll carries into hundreds, on the same clk_i edge. bcd_o never exceeds 9.
- R4: While cnt_dis_i is high, a falling cnt_clk_i does not change the count.
- R5: When clear_i is sampled high, the count, all stored digits and carry_o go to zero and the scan returns to units, whatever the other inputs are. From the next edge on, bcd_o = 0 and dig_sel_o = 3'b001. Clear takes precedence over counting and scanning.
- R6: While hold_i is high, each presented digit keeps the value the count had on the last edge at which hold_i was low, even as counting goes on. While hold_i is low, the presented digits follow the live count in the same cycle the count changes.
- R7: Each scan_tick_i pulse steps the selection units → tens → hundreds → units. dig_sel_o is one-hot, with bit 0 for units, bit 1 for tens and bit 2 for hundreds. bcd_o carries the digit named by dig_sel_o, and both change on the same edge.
- R8: carry_o goes high on the accepted advance from 999 to 000. It stays high until the next accepted advance or a clear, so a disabled falling edge does not end it.
- R9: A scan tick and an accepted count edge that arrive in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_clk_i | input | 1 | Count clock; its falling transition is the counted event |
| cnt_dis_i | input | 1 | High blocks counting |
| hold_i | input | 1 | High freezes the presented digits |
| clear_i | input | 1 | Synchronous master clear, active high |
| scan_tick_i | input | 1 | One-cycle pulse that advances the digit scan |
| bcd_o | output | 4 | Presented digit in BCD |
| dig_sel_o | output | 3 | One-hot select of the presented digit |
| carry_o | output | 1 | Wrap flag used to chain further stages |

## Verification
A digit that carries at the wrong count shows up on bcd_o only while that decade is selected, so the bench scans all three positions after each scenario rather than watching units alone. An error in the hold stage shows up as soon as the count moves under a closed hold. An error in the scan index shows up as a wrong one-hot code or a wrong digit paired with it on the next tick. A wrong carry state shows up on carry_o on the edge after the 999 wrap, and again when a disabled edge must not clear it.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t digit_o,
  output bcd_t digit_next_o,
  output logic wrap_o
);
  bcd_t digit_q, digit_d;

  assign wrap_o = inc_i && (digit_q == bcd_t'(DIGIT_MAX));

  always_comb begin
    digit_d = digit_q;
    if (clr_i)       digit_d = '0;
    else if (wrap_o) digit_d = '0;
    else if (inc_i)  digit_d = digit_q + bcd_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) digit_q <= '0;
    else         digit_q <= digit_d;
  end

  assign digit_o      = digit_q;
  assign digit_next_o = digit_d;
endmodule

// File: rtl/digit_hold.sv
module digit_hold
  import bcd_scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hold_i,
  input  bcd_t live_i,
  input  bcd_t live_next_i,
  output bcd_t digit_o
);
  bcd_t store_q;

  // store tracks the next count while open, so closing never loses an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      store_q <= '0;
    else if (clr_i)   store_q <= '0;
    else if (!hold_i) store_q <= live_next_i;
  end

  assign digit_o = hold_i ? store_q : live_i;
endmodule

// File: rtl/scan_mux.sv
module scan_mux
  import bcd_scan_pkg::*;
#(
  parameter int unsigned N_DIGITS = 3,
  localparam int unsigned IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                tick_i,
  input  bcd_t [N_DIGITS-1:0] digits_i,
  output bcd_t                bcd_o,
  output logic [N_DIGITS-1:0] sel_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIGITS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idx_q <= '0;
    else if (clr_i)          idx_q <= '0;
    else if (tick_i) begin
      if (idx_q == LAST)     idx_q <= '0;
      else                   idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_sel
    assign sel_o[g] = (idx_q == IDX_W'(g));
  end

  assign bcd_o = digits_i[idx_q];
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter
  import bcd_scan_pkg::*;
#(
  parameter int unsigned N_DIGITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnt_clk_i,
  input  logic                cnt_dis_i,
  input  logic                hold_i,
  input  logic                clear_i,
  input  logic                scan_tick_i,
  output logic [DIGIT_W-1:0]  bcd_o,
  output logic [N_DIGITS-1:0] dig_sel_o,
  output logic                carry_o
);
  logic cnt_clk_q;
  logic advance;
  logic carry_q;

  logic [N_DIGITS:0]   inc;
  logic [N_DIGITS-1:0] wrap;
  bcd_t [N_DIGITS-1:0] live, live_next, shown;
  logic [N_DIGITS*DIGIT_W-1:0] cnt_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_clk_q <= 1'b0;
    else         cnt_clk_q <= cnt_clk_i;
  end

  assign advance = cnt_clk_q && !cnt_clk_i && !cnt_dis_i;
  assign inc[0]  = advance;

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_dec
    bcd_decade i_dec (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clear_i),
      .inc_i        (inc[g]),
      .digit_o      (live[g]),
      .digit_next_o (live_next[g]),
      .wrap_o       (wrap[g])
    );
    assign inc[g+1] = wrap[g];

    digit_hold i_hold (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clear_i),
      .hold_i      (hold_i),
      .live_i      (live[g]),
      .live_next_i (live_next[g]),
      .digit_o     (shown[g])
    );
    assign cnt_flat[g*DIGIT_W +: DIGIT_W] = live[g];
  end

  scan_mux #(.N_DIGITS(N_DIGITS)) i_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clear_i),
    .tick_i   (scan_tick_i),
    .digits_i (shown),
    .bcd_o    (bcd_o),
    .sel_o    (dig_sel_o)
  );

  // carry lasts until the next accepted advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      carry_q <= 1'b0;
    else if (clear_i) carry_q <= 1'b0;
    else if (advance) carry_q <= inc[N_DIGITS];
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/bcd_scan_counter_chk.sv
module bcd_scan_counter_chk #(
  parameter int unsigned N_DIGITS = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cnt_dis_i,
  input logic                  hold_i,
  input logic                  clear_i,
  input logic                  scan_tick_i,
  input logic [3:0]            bcd_o,
  input logic [N_DIGITS-1:0]   dig_sel_o,
  input logic                  carry_o,
  input logic [N_DIGITS*4-1:0] cnt_flat
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(dig_sel_o)); // R7
  AST_SCAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_tick_i && !clear_i) |=>
      dig_sel_o == {$past(dig_sel_o[N_DIGITS-2:0]), $past(dig_sel_o[N_DIGITS-1])}); // R7
  AST_SCAN_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_tick_i && !clear_i) |=> $stable(dig_sel_o)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (bcd_o == 4'd0 && dig_sel_o[0] && !carry_o && cnt_flat == '0)); // R5
  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_o <= 4'd9); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i && !scan_tick_i) |=> (!hold_i || $stable(bcd_o))); // R6
  AST_DISABLE_NOCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dis_i && !clear_i) |=> $stable(cnt_flat)); // R4
  AST_CARRY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(carry_o) |-> cnt_flat == '0); // R8
endmodule

bind bcd_scan_counter bcd_scan_counter_chk #(.N_DIGITS(N_DIGITS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_dis_i   (cnt_dis_i),
  .hold_i      (hold_i),
  .clear_i     (clear_i),
  .scan_tick_i (scan_tick_i),
  .bcd_o       (bcd_o),
  .dig_sel_o   (dig_sel_o),
  .carry_o     (carry_o),
  .cnt_flat    (cnt_flat)
);

// File: tb/test_bcd_scan_counter.sv
module test_bcd_scan_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_clk_i = 1'b0, cnt_dis_i = 1'b0, hold_i = 1'b0;
  logic       clear_i = 1'b0, scan_tick_i = 1'b0;
  logic [3:0] bcd_o;
  logic [2:0] dig_sel_o;
  logic       carry_o;

  bcd_scan_counter i_bcd_scan_counter (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {string tag; int bcd; int sel; int carry;} exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  int ref_cnt = 0, ref_held = 0, ref_idx = 0, ref_carry = 0;
  bit ref_hold = 0;

  function automatic int pow10(int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  task automatic expect_now(string tag);
    exp_t e;
    int disp = ref_hold ? ref_held : ref_cnt;
    e.tag = tag;
    e.bcd = (disp / pow10(ref_idx)) % 10;
    e.sel = 1 << ref_idx;
    e.carry = ref_carry;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected items and compares against the ports
  initial forever begin
    exp_t e;
    wait (exp_q.size() != 0);
    e = exp_q.pop_front();
    n_chk++;
    if (int'(bcd_o) != e.bcd || int'(dig_sel_o) != e.sel || int'(carry_o) != e.carry) begin
      n_fail++;
      $display("FAIL %s: bcd=%0d sel=%b carry=%0b expected bcd=%0d sel=%b carry=%0b",
               e.tag, bcd_o, dig_sel_o, carry_o, e.bcd, e.sel[2:0], e.carry);
    end
  end

  task automatic model_adv();
    ref_carry = (ref_cnt == 999);
    ref_cnt = (ref_cnt + 1) % 1000;
    if (!ref_hold) ref_held = ref_cnt;
  endtask

  task automatic pulse(bit dis);
    @(negedge clk_i) begin cnt_clk_i = 1'b1; cnt_dis_i = dis; end
    @(negedge clk_i) cnt_clk_i = 1'b0;
    @(negedge clk_i) cnt_dis_i = 1'b0;
    if (!dis) model_adv();
  endtask

  task automatic count_n(int n);
    for (int i = 0; i < n; i++) pulse(1'b0);
  endtask

  task automatic scan_step();
    @(negedge clk_i) scan_tick_i = 1'b1;
    @(negedge clk_i) scan_tick_i = 1'b0;
    ref_idx = (ref_idx + 1) % 3;
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 3; k++) begin
      expect_now(tag);
      scan_step();
    end
  endtask

  task automatic set_hold(bit h);
    @(negedge clk_i) hold_i = h;
    ref_hold = h;
    if (!h) ref_held = ref_cnt;
  endtask

  task automatic do_clear();
    @(negedge clk_i) clear_i = 1'b1;
    @(negedge clk_i) clear_i = 1'b0;
    ref_cnt = 0; ref_held = 0; ref_idx = 0; ref_carry = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_now("R1 reset state");

    // rising edge alone must not count
    @(negedge clk_i) cnt_clk_i = 1'b1;
    @(negedge clk_i);
    expect_now("R2 rising edge ignored");
    cnt_clk_i = 1'b0;
    @(negedge clk_i);
    model_adv();
    expect_now("R2 falling edge counts");

    count_n(8);
    expect_now("R2 units at 9");
    pulse(1'b0);
    read_all("R3 units-to-tens carry");

    pulse(1'b1);
    read_all("R4 disabled edge ignored");

    count_n(113);
    read_all("R3 R7 digit pairing at 123");

    set_hold(1'b1);
    count_n(5);
    read_all("R6 hold keeps 123");
    set_hold(1'b0);
    read_all("R6 release follows 128");

    scan_step();
    set_hold(1'b1);
    count_n(3);
    do_clear();
    expect_now("R5 clear under hold");
    read_all("R5 all digits zero");
    set_hold(1'b0);

    count_n(999);
    read_all("R3 count 999");
    pulse(1'b0);
    expect_now("R8 carry on wrap");
    pulse(1'b1);
    expect_now("R8 carry kept over disabled edge");
    pulse(1'b0);
    expect_now("R8 carry ends on next advance");

    // count and scan in the same cycle
    @(negedge clk_i) cnt_clk_i = 1'b1;
    @(negedge clk_i) begin cnt_clk_i = 1'b0; scan_tick_i = 1'b1; end
    @(negedge clk_i) scan_tick_i = 1'b0;
    model_adv();
    ref_idx = (ref_idx + 1) % 3;
    expect_now("R9 tens after joint step");
    scan_step(); scan_step();
    expect_now("R9 units after joint step");

    #1;
    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule